// File: doc/BRIEF.md
# Carry-Select Lookup ALU

This block is a 16-bit arithmetic and logic unit assembled from four identical 4-bit slices. Each slice behaves as a fixed lookup function: a 14-bit address formed from its operand nibbles, the 5-bit operation code and a carry-in bit selects a 6-bit word. That word holds the result nibble together with the slice's group propagate and group generate. Every slice reads its word twice in parallel, once with carry-in 0 and once with carry-in 1. A lookahead network then derives the real carry into each slice from the slice propagate/generate terms, and a 2:1 multiplexer per slice keeps the matching nibble. No slice is evaluated a second time and no carry ripples through the result logic.

Operands enter on a valid/ready stream and results leave on another. A transfer takes place on any rising clock edge where both valid and ready are high. With the default `REG_OUT = 1` the result sits in one output register. The input side is ready whenever that register is empty or is being drained in the same cycle. While the downstream side holds ready low, the registered result and its valid stay frozen. With `REG_OUT = 0` the block is purely combinational, and valid and ready pass straight through.

Top module: `tsel_alu`

## Requirements
- R1: Operation code 0 gives y = (a + b) mod 2^16, and cout is the carry out of bit 15.
- R2: Operation code 1 gives y = (a + b + cin) mod 2^16, and cout is the carry out of that sum.
- R3: Operation code 2 gives y = (a − b) mod 2^16 by computing a + ~b + 1. cout is 1 exactly when a ≥ b unsigned, so it reads as active-high "no borrow".
- R4: Operation code 3 gives y = a + ~b + cin, with cout as the carry out of that sum. cin = 1 means no borrow pending.
- R5: Operation codes 4, 5, 6 and 7 give a AND b, a OR b, a XOR b and NOT a, in that order. cin has no effect on them and cout is 0.
- R6: Operation code 8 passes a and operation code 9 passes b. cin has no effect and cout is 0.
- R7: Operation code 10 gives a + 1, with cout = 1 only for a = 0xFFFF. Operation code 11 gives a − 1, computed as a + 0xFFFF, with cout = 1 for every a except 0. Codes 12 to 31 give y = 0 and cout = 0.
- R8: zero is 1 exactly when all 16 bits of y are 0. It is valid together with y.
- R9: With REG_OUT = 1, the result of a transfer accepted on one clock edge shows up with out_valid after that edge. in_ready equals !out_valid || out_ready. While out_valid is high and out_ready is low, y, cout and zero hold steady.
- R10: While rst_n is low, and after reset, out_valid is 0 until the first input transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand set is present |
| in_ready | output | 1 | Block can take an operand set |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| sel | input | 5 | Operation code |
| cin | input | 1 | Carry / no-borrow input |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Downstream takes the result |
| y | output | 16 | Result |
| cout | output | 1 | Carry out of the top slice |
| zero | output | 1 | Result is all zeros |

## Verification
Under the default configuration, each accepted operand set has its y, cout and zero due one cycle after the edge that accepted it. They stay there for as many further cycles as out_ready is held low. The bench never counts cycles to line results up. Instead it pushes each expected result into a queue at the moment the handshake shows acceptance, and it pops one entry on each output handshake. Ordering therefore follows the stream rules rather than a fixed delay. Random back-pressure on out_ready exercises both the one-cycle case and longer stalls. During a stall the bench checks that the held output does not move.

// File: rtl/tsel_alu_pkg.sv
package tsel_alu_pkg;

  localparam int NIB   = 4;
  localparam int SELW  = 5;
  localparam int ADDRW = 2 * NIB + SELW + 1;

  typedef enum logic [SELW-1:0] {
    OP_ADD   = 5'd0,
    OP_ADC   = 5'd1,
    OP_SUB   = 5'd2,
    OP_SBC   = 5'd3,
    OP_AND   = 5'd4,
    OP_OR    = 5'd5,
    OP_XOR   = 5'd6,
    OP_NOTA  = 5'd7,
    OP_PASSA = 5'd8,
    OP_PASSB = 5'd9,
    OP_INCA  = 5'd10,
    OP_DECA  = 5'd11
  } op_e;

  typedef struct packed {
    logic           g;
    logic           p;
    logic [NIB-1:0] r;
  } lut_word_t;

  // One slice table entry; address = {a_nib, b_nib, op, ci}
  function automatic lut_word_t lut_entry(input logic [ADDRW-1:0] addr);
    logic [NIB-1:0] av, bv, yo;
    logic [SELW-1:0] op;
    logic ci, arith;
    logic [NIB:0] sum, gen;
    lut_word_t w;
    av    = addr[ADDRW-1 -: NIB];
    bv    = addr[ADDRW-1-NIB -: NIB];
    op    = addr[SELW:1];
    ci    = addr[0];
    arith = 1'b0;
    yo    = '0;
    w     = '0;
    case (op)
      OP_ADD, OP_ADC:  begin arith = 1'b1; yo = bv;        end
      OP_SUB, OP_SBC:  begin arith = 1'b1; yo = ~bv;       end
      OP_INCA:         begin arith = 1'b1; yo = '0;        end
      OP_DECA:         begin arith = 1'b1; yo = '1;        end
      OP_AND:          w.r = av & bv;
      OP_OR:           w.r = av | bv;
      OP_XOR:          w.r = av ^ bv;
      OP_NOTA:         w.r = ~av;
      OP_PASSA:        w.r = av;
      OP_PASSB:        w.r = bv;
      default:         w.r = '0;
    endcase
    if (arith) begin
      sum = {1'b0, av} + {1'b0, yo} + {{NIB{1'b0}}, ci};
      gen = {1'b0, av} + {1'b0, yo};
      w.r = sum[NIB-1:0];
      w.p = &(av ^ yo);
      w.g = gen[NIB];
    end
    return w;
  endfunction

  // Carry entering the least significant slice
  function automatic logic base_carry(input logic [SELW-1:0] op, input logic cin);
    case (op)
      OP_ADC, OP_SBC:  return cin;
      OP_SUB, OP_INCA: return 1'b1;
      default:         return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/tsel_alu_slice.sv
module tsel_alu_slice
  import tsel_alu_pkg::*;
(
  input  logic [NIB-1:0]  a_nib,
  input  logic [NIB-1:0]  b_nib,
  input  logic [SELW-1:0] op,
  output logic [NIB-1:0]  res_c0,
  output logic [NIB-1:0]  res_c1,
  output logic            grp_p,
  output logic            grp_g
);

  lut_word_t word [2];

  for (genvar ci = 0; ci < 2; ci++) begin : g_port
    always_comb word[ci] = lut_entry({a_nib, b_nib, op, ci[0]});
  end

  assign res_c0 = word[0].r;
  assign res_c1 = word[1].r;
  assign grp_p  = word[0].p;
  assign grp_g  = word[0].g;

endmodule

// File: rtl/tsel_alu_cla.sv
module tsel_alu_cla #(
  parameter int NS = 4
) (
  input  logic [NS-1:0] p,
  input  logic [NS-1:0] g,
  input  logic          c0,
  output logic [NS-1:0] c_in,
  output logic          c_out
);

  logic [NS:0] cc;

  // Two-level sum of products per carry: no term depends on another carry
  always_comb begin
    logic prod;
    cc = '0;
    for (int i = 0; i <= NS; i++) begin
      for (int j = -1; j < i; j++) begin
        prod = (j < 0) ? c0 : g[j];
        for (int k = j + 1; k < i; k++) prod = prod & p[k];
        cc[i] = cc[i] | prod;
      end
    end
  end

  assign c_in  = cc[NS-1:0];
  assign c_out = cc[NS];

endmodule

// File: rtl/tsel_alu_ostage.sv
module tsel_alu_ostage #(
  parameter int DW      = 18,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);

  if (REG_OUT) begin : g_reg
    logic          vld_q;
    logic [DW-1:0] dat_q;
    assign in_ready = !vld_q || out_ready;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        dat_q <= '0;
      end else if (in_ready) begin
        vld_q <= in_valid;
        if (in_valid) dat_q <= in_data;
      end
    end
    assign out_valid = vld_q;
    assign out_data  = dat_q;
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk ^ rst_n;
    assign in_ready   = out_ready;
    assign out_valid  = in_valid;
    assign out_data   = in_data;
  end

endmodule

// File: rtl/tsel_alu.sv
module tsel_alu
  import tsel_alu_pkg::*;
#(
  parameter int W       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [SELW-1:0] sel,
  input  logic            cin,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [W-1:0]    y,
  output logic            cout,
  output logic            zero
);

  localparam int NS = W / NIB;
  localparam int DW = W + 2;

  logic [NS-1:0]  sp, sg, sc;
  logic [NIB-1:0] r0 [NS];
  logic [NIB-1:0] r1 [NS];
  logic [W-1:0]   y_comb;
  logic           c_top, c_base;

  for (genvar i = 0; i < NS; i++) begin : g_slice
    tsel_alu_slice u_slice (
      .a_nib  (a[i*NIB +: NIB]),
      .b_nib  (b[i*NIB +: NIB]),
      .op     (sel),
      .res_c0 (r0[i]),
      .res_c1 (r1[i]),
      .grp_p  (sp[i]),
      .grp_g  (sg[i])
    );
    assign y_comb[i*NIB +: NIB] = sc[i] ? r1[i] : r0[i];
  end

  assign c_base = base_carry(sel, cin);

  tsel_alu_cla #(.NS(NS)) u_cla (
    .p     (sp),
    .g     (sg),
    .c0    (c_base),
    .c_in  (sc),
    .c_out (c_top)
  );

  logic [DW-1:0] pack_in, pack_out;
  assign pack_in = {c_top, ~|y_comb, y_comb};

  tsel_alu_ostage #(.DW(DW), .REG_OUT(REG_OUT)) u_ostage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pack_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pack_out)
  );

  assign y    = pack_out[W-1:0];
  assign zero = pack_out[W];
  assign cout = pack_out[W+1];

endmodule

// File: rtl/tsel_alu_chk.sv
module tsel_alu_chk #(
  parameter int W       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [4:0]   sel,
  input logic         cin,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] y,
  input logic         cout,
  input logic         zero
);

  logic acc;
  assign acc = in_valid && in_ready;

  a_r8_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (zero == (y == '0)));

  if (REG_OUT) begin : g_reg
    a_r1_add_sum: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && sel == 5'd0) |=> ({cout, y} == ({1'b0, $past(a)} + {1'b0, $past(b)})));

    a_r3_sub_borrow: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && sel == 5'd2) |=> (y == W'($past(a) - $past(b)) && cout == ($past(a) >= $past(b))));

    a_r5_logic_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && sel >= 5'd4 && sel <= 5'd9) |=> !cout);

    a_r9_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(y) && $stable(cout) && $stable(zero)));

    a_r9_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> out_valid);

    a_r10_empty_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);
  end

endmodule

bind tsel_alu tsel_alu_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/tsel_alu_tb.sv
module tsel_alu_tb;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] a = '0, b = '0;
  logic [4:0]   sel = '0;
  logic         cin = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] y;
  logic         cout, zero;

  always #2 clk = ~clk;

  tsel_alu u_dut (.*);

  typedef struct {
    logic [W-1:0] y;
    logic         c;
    logic [4:0]   op;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;
  bit done = 1'b0;

  function automatic string req_of(input logic [4:0] op);
    if (op == 0) return "R1";
    if (op == 1) return "R2";
    if (op == 2) return "R3";
    if (op == 3) return "R4";
    if (op <= 7) return "R5";
    if (op <= 9) return "R6";
    return "R7";
  endfunction

  function automatic exp_t model(input logic [W-1:0] x, input logic [W-1:0] z,
                                 input logic [4:0] op, input logic ci);
    logic [W:0] s;
    exp_t e;
    case (op)
      5'd0:  s = {1'b0, x} + {1'b0, z};
      5'd1:  s = {1'b0, x} + {1'b0, z} + (W+1)'(ci);
      5'd2:  s = {1'b0, x} + {1'b0, ~z} + 1'b1;
      5'd3:  s = {1'b0, x} + {1'b0, ~z} + (W+1)'(ci);
      5'd4:  s = {1'b0, x & z};
      5'd5:  s = {1'b0, x | z};
      5'd6:  s = {1'b0, x ^ z};
      5'd7:  s = {1'b0, ~x};
      5'd8:  s = {1'b0, x};
      5'd9:  s = {1'b0, z};
      5'd10: s = {1'b0, x} + 1'b1;
      5'd11: s = {1'b0, x} + {1'b0, 16'hFFFF};
      default: s = '0;
    endcase
    e.y = s[W-1:0];
    e.c = s[W];
    e.op = op;
    return e;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [W-1:0] x, input logic [W-1:0] z,
                      input logic [4:0] op, input logic ci);
    @(negedge clk);
    a = x; b = z; sel = op; cin = ci; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    q.push_back(model(x, z, op, ci));
  endtask

  // Monitor: random back-pressure, pop and compare on each output handshake
  initial begin : monitor
    logic         held = 1'b0;
    logic [W-1:0] hy;
    logic         hc, hz;
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n) out_ready = ($urandom % 4) != 0;
      #1;
      if (rst_n) begin
        if (held) begin
          check("R9", "stall_valid", W'(out_valid), W'(1));
          check("R9", "stall_y", y, hy);
          check("R9", "stall_flags", W'({cout, zero}), W'({hc, hz}));
        end
        held = 1'b0;
        if (out_valid) begin
          if (out_ready) begin
            if (q.size() == 0) begin
              check("R9", "unexpected_result", W'(1), W'(0));
            end else begin
              e = q.pop_front();
              check(req_of(e.op), $sformatf("y op=%0d", e.op), y, e.y);
              check(req_of(e.op), $sformatf("cout op=%0d", e.op), W'(cout), W'(e.c));
              check("R8", "zero", W'(zero), W'(e.y == '0));
            end
          end else begin
            held = 1'b1; hy = y; hc = cout; hz = zero;
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    logic [W-1:0] ca [6] = '{16'hFFFF, 16'h0000, 16'h0000, 16'hFFFF, 16'h8000, 16'h1234};
    logic [W-1:0] cb [6] = '{16'h0001, 16'h0001, 16'h0000, 16'hFFFF, 16'h8000, 16'h1234};
    repeat (3) @(posedge clk);
    #1;
    check("R10", "out_valid_in_reset", W'(out_valid), W'(0));
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R10", "out_valid_after_reset", W'(out_valid), W'(0));
    for (int op = 0; op < 32; op++) begin
      for (int k = 0; k < 6; k++) begin
        send(ca[k], cb[k], 5'(op), 1'b0);
        send(ca[k], cb[k], 5'(op), 1'b1);
      end
      for (int k = 0; k < 20; k++) send(16'($urandom), 16'($urandom), 5'(op), 1'($urandom));
    end
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < 200 && q.size() != 0; k++) @(negedge clk);
    repeat (2) @(negedge clk);
    check("R9", "queue_drained", W'(q.size()), W'(0));
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule